// File: doc/BRIEF.md
# Block Completion Interrupt Unit

This unit turns the end-of-block events of one transfer channel into interrupt status. It records three sticky conditions (a block finished, the whole transfer finished, the awaited final write came back with an error response) and drives one level interrupt line. It is the OR of every status bit that is both set and enabled for signalling. Software clears status bits through a write-one-to-clear port.

Whether a finished block raises its status depends on an interrupt-on-completion flag. In per-block mode (descriptor chains or shadow registers), the flag is read at the moment each block ends. In fixed mode (contiguous or auto-reload transfers), the flag is captured when the channel is enabled and then applies to every block. When the non-posted-last-write option is on, the block is not reported at its end. The unit waits for the write response that belongs to the write flagged as the block's last. It finds that response by counting outstanding writes, because responses return in issue order.

Top module: `blk_irq_unit`

## Requirements
- R1: After reset all status bits are 0 and `irq` is 0.
- R2: Status bit 0 (block done) sets on a block completion only when the effective completion flag is 1, the response was not an error, and `sts_en[0]` is 1. It is visible in the cycle after the completion.
- R3: Status bit 1 (transfer done) sets on the completion of a block marked `blk_final` when `sts_en[1]` is 1. The completion flag does not affect this bit.
- R4: `irq` is a level equal to the OR of `sts & sig_en`. It follows `sig_en` changes without any new event.
- R5: With `per_block`=1 the flag is `cfg_ioc` in the `blk_end` cycle. With `per_block`=0 the flag is the `cfg_ioc` value captured at the last `chan_en` pulse, and later `cfg_ioc` changes have no effect.
- R6: With `np_last_en`=0 the block completes in its `blk_end` cycle. Write responses neither delay nor trigger a completion.
- R7: With `np_last_en`=1 the block completes only once both `blk_end` and the response to the write issued with `wr_issue_last` have been seen, in either order or in the same cycle. Earlier responses do not complete it.
- R8: If that awaited response has `b_err`=1, status bit 2 (error) sets when `sts_en[2]` is 1, in place of bit 0.
- R9: Status bits hold until a `clr_we` cycle with the matching `clr_mask` bit at 1. A set and a clear of the same bit in one cycle leaves the bit set. Clearing one bit leaves the others untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel-enable pulse; captures `cfg_ioc` for fixed mode |
| per_block | input | 1 | 1: flag taken per block; 0: flag fixed at enable |
| cfg_ioc | input | 1 | Interrupt-on-completion flag |
| np_last_en | input | 1 | 1: last write of a block is non-posted and awaited |
| blk_end | input | 1 | Pulse: data engine finished issuing a block |
| blk_final | input | 1 | With `blk_end`: this is the last block of the transfer |
| wr_issue | input | 1 | Pulse: one write issued |
| wr_issue_last | input | 1 | With `wr_issue`: this write is the block's last |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_err | input | 1 | Write response reports an error |
| sts_en | input | 3 | Status-enable mask (bit 0 block, 1 transfer, 2 error) |
| sig_en | input | 3 | Signal-enable mask, same bit order |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | 3 | Write-one-to-clear bits |
| sts | output | 3 | Sticky status (bit 0 block, 1 transfer, 2 error) |
| irq | output | 1 | Combined interrupt level |

## Verification
The bench sends a final write response before, after, and in the same cycle as `blk_end`. A tracker that ignored one of these orders would drop or repeat a block-done. It also sends an earlier response ahead of the flagged one, which a design that did not count outstanding writes would accept as the last. In fixed mode the bench changes `cfg_ioc` after the enable pulse; a design that did not capture the flag would report the wrong blocks. It also issues a set and a clear of the same bit in one cycle, where a design giving the clear priority would lose the interrupt. Finally, it returns an erroring final response, which must raise the error bit and must not raise block done.

// File: rtl/blk_irq_pkg.sv
package blk_irq_pkg;
    localparam int unsigned STS_W    = 3;
    localparam int unsigned BIT_BLK  = 0;
    localparam int unsigned BIT_XFER = 1;
    localparam int unsigned BIT_ERR  = 2;

    typedef struct packed {
        logic valid;
        logic final_blk;
        logic ioc;
        logic err;
    } done_evt_t;
endpackage

// File: rtl/blk_irq_ioc_sel.sv
module blk_irq_ioc_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic per_block,
    input  logic cfg_ioc,
    output logic ioc_eff
);
    typedef struct packed {
        logic ioc_cap;
    } sel_st_t;

    sel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (chan_en) st_d.ioc_cap = cfg_ioc;
        ioc_eff = per_block ? cfg_ioc : st_q.ioc_cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: the captured flag only moves on an enable pulse
    assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> $stable(st_q.ioc_cap));
endmodule

// File: rtl/blk_irq_tracker.sv
module blk_irq_tracker
    import blk_irq_pkg::*;
#(
    parameter int unsigned MAX_OUT = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      blk_end,
    input  logic      blk_final,
    input  logic      ioc_eff,
    input  logic      np_last_en,
    input  logic      wr_issue,
    input  logic      wr_issue_last,
    input  logic      b_valid,
    input  logic      b_ready,
    input  logic      b_err,
    output done_evt_t done
);
    localparam int unsigned CW = $clog2(MAX_OUT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] mark;
        logic          rsp_seen;
        logic          rsp_err;
        logic          blk_seen;
        logic          blk_final;
        logic          blk_ioc;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic    rsp;
    logic    hit;
    logic    rsp_done;
    logic    err_v;
    logic    pend;

    always_comb begin
        st_d     = st_q;
        done     = '0;
        rsp      = b_valid & b_ready;
        hit      = rsp && (st_q.mark == CW'(1));
        rsp_done = st_q.rsp_seen | hit;
        err_v    = hit ? b_err : st_q.rsp_err;
        pend     = 1'b0;

        st_d.cnt = st_q.cnt + CW'(wr_issue) - CW'(rsp);
        if (rsp && (st_q.mark != '0)) st_d.mark = st_q.mark - CW'(1);
        if (wr_issue && wr_issue_last && np_last_en)
            st_d.mark = st_q.cnt - CW'(rsp) + CW'(1);

        if (hit) begin
            st_d.rsp_seen = 1'b1;
            st_d.rsp_err  = b_err;
        end

        if (blk_end && !np_last_en) begin
            done.valid     = 1'b1;
            done.final_blk = blk_final;
            done.ioc       = ioc_eff;
            done.err       = 1'b0;
        end else begin
            pend = st_q.blk_seen | blk_end;
            if (blk_end) begin
                st_d.blk_seen  = 1'b1;
                st_d.blk_final = blk_final;
                st_d.blk_ioc   = ioc_eff;
            end
            if (pend && rsp_done) begin
                done.valid     = 1'b1;
                done.final_blk = blk_end ? blk_final : st_q.blk_final;
                done.ioc       = blk_end ? ioc_eff : st_q.blk_ioc;
                done.err       = err_v;
                st_d.blk_seen  = 1'b0;
                st_d.rsp_seen  = 1'b0;
                st_d.rsp_err   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: outstanding-write counter stays in range
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CW'(MAX_OUT)) |-> !(wr_issue && !rsp));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> !rsp);
    // R7: a waiting block is not reported before its response
    assert_wait_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.blk_seen && !st_q.rsp_seen && !hit) |-> !done.valid);
    // R8: an error completion needs an awaited response
    assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done.valid && done.err) |-> (hit || st_q.rsp_seen));
endmodule

// File: rtl/blk_irq_status.sv
module blk_irq_status
    import blk_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  done_evt_t        done,
    input  logic [STS_W-1:0] sts_en,
    input  logic [STS_W-1:0] sig_en,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_mask,
    output logic [STS_W-1:0] sts,
    output logic             irq
);
    typedef struct packed {
        logic [STS_W-1:0] sts;
    } sts_st_t;

    sts_st_t          st_d, st_q;
    logic [STS_W-1:0] set_v;
    logic [STS_W-1:0] clr_v;

    always_comb begin
        set_v           = '0;
        set_v[BIT_BLK]  = done.valid & done.ioc & ~done.err & sts_en[BIT_BLK];
        set_v[BIT_XFER] = done.valid & done.final_blk & sts_en[BIT_XFER];
        set_v[BIT_ERR]  = done.valid & done.err & sts_en[BIT_ERR];
        clr_v           = clr_we ? clr_mask : '0;
        st_d.sts        = (st_q.sts & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign irq = |(st_q.sts & sig_en);

    generate
        for (genvar b = 0; b < STS_W; b++) begin : g_sticky
            // R9: a set bit survives any cycle without its clear
            assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.sts[b] && !(clr_we && clr_mask[b])) |=> st_q.sts[b]);
        end
    endgenerate

    // R2: block-done only rises with its status enable
    assert_blk_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sts[BIT_BLK]) |-> $past(sts_en[BIT_BLK]));
    // R8: error replaces block-done, never both at once
    assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(st_q.sts[BIT_BLK]) && $rose(st_q.sts[BIT_ERR])));
endmodule

// File: rtl/blk_irq_unit.sv
module blk_irq_unit
    import blk_irq_pkg::*;
#(
    parameter int unsigned MAX_OUT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       per_block,
    input  logic       cfg_ioc,
    input  logic       np_last_en,
    input  logic       blk_end,
    input  logic       blk_final,
    input  logic       wr_issue,
    input  logic       wr_issue_last,
    input  logic       b_valid,
    input  logic       b_ready,
    input  logic       b_err,
    input  logic [2:0] sts_en,
    input  logic [2:0] sig_en,
    input  logic       clr_we,
    input  logic [2:0] clr_mask,
    output logic [2:0] sts,
    output logic       irq
);
    logic      ioc_eff;
    done_evt_t done;

    blk_irq_ioc_sel i_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .per_block (per_block),
        .cfg_ioc   (cfg_ioc),
        .ioc_eff   (ioc_eff)
    );

    blk_irq_tracker #(.MAX_OUT(MAX_OUT)) i_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .blk_end       (blk_end),
        .blk_final     (blk_final),
        .ioc_eff       (ioc_eff),
        .np_last_en    (np_last_en),
        .wr_issue      (wr_issue),
        .wr_issue_last (wr_issue_last),
        .b_valid       (b_valid),
        .b_ready       (b_ready),
        .b_err         (b_err),
        .done          (done)
    );

    blk_irq_status i_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .sts_en   (sts_en),
        .sig_en   (sig_en),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .sts      (sts),
        .irq      (irq)
    );

    // R1: irq never asserts with empty status
    assert_irq_needs_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts != '0));
endmodule

// File: tb/test_blk_irq_unit.sv
module test_blk_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0, per_block = 1'b1, cfg_ioc = 1'b1, np_last_en = 1'b0;
    logic       blk_end = 1'b0, blk_final = 1'b0;
    logic       wr_issue = 1'b0, wr_issue_last = 1'b0;
    logic       b_valid = 1'b0, b_ready = 1'b0, b_err = 1'b0;
    logic [2:0] sts_en = 3'b111, sig_en = 3'b111, clr_mask = 3'b000;
    logic       clr_we = 1'b0;
    logic [2:0] sts;
    logic       irq;

    typedef struct {
        logic [2:0] sts;
        logic       irq;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    blk_irq_unit i_blk_irq_unit (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .per_block(per_block),
        .cfg_ioc(cfg_ioc), .np_last_en(np_last_en), .blk_end(blk_end),
        .blk_final(blk_final), .wr_issue(wr_issue), .wr_issue_last(wr_issue_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_err(b_err), .sts_en(sts_en),
        .sig_en(sig_en), .clr_we(clr_we), .clr_mask(clr_mask), .sts(sts), .irq(irq)
    );

    // monitor: compares after each edge, once outputs settled
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (sts !== e.sts || irq !== e.irq) begin
                errors++;
                $display("FAIL %s: sts=%b irq=%b expected sts=%b irq=%b",
                         e.req, sts, irq, e.sts, e.irq);
            end
        end
    end

    // driver: inputs were set at the falling edge; push what the next edge yields
    task automatic tick(input logic [2:0] es, input logic ei, input string rq);
        exp_t e;
        @(posedge clk);
        e.sts = es; e.irq = ei; e.req = rq;
        exp_q.push_back(e);
        @(negedge clk);
        chan_en = 0; blk_end = 0; blk_final = 0; wr_issue = 0; wr_issue_last = 0;
        b_valid = 0; b_ready = 0; b_err = 0; clr_we = 0; clr_mask = 0;
    endtask

    task automatic clear_all();
        clr_we = 1; clr_mask = 3'b111;
        tick(3'b000, 1'b0, "R9");
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        tick(3'b000, 1'b0, "R1");

        // R6: posted mode completes at blk_end; a flagged write is not awaited
        blk_end = 1; cfg_ioc = 1; wr_issue = 1; wr_issue_last = 1;
        tick(3'b001, 1'b1, "R6");
        clr_we = 1; clr_mask = 3'b001;
        tick(3'b000, 1'b0, "R9");
        b_valid = 1; b_ready = 1;
        tick(3'b000, 1'b0, "R6");

        // R2: gated by flag and by status enable
        cfg_ioc = 0; blk_end = 1;
        tick(3'b000, 1'b0, "R2");
        cfg_ioc = 1; sts_en = 3'b110; blk_end = 1;
        tick(3'b000, 1'b0, "R2");
        sts_en = 3'b111;

        // R3: final block sets transfer done
        blk_end = 1; blk_final = 1;
        tick(3'b011, 1'b1, "R3");
        clear_all();
        cfg_ioc = 0; blk_end = 1; blk_final = 1;
        tick(3'b010, 1'b1, "R3");
        clear_all();
        cfg_ioc = 1;

        // R4: irq follows signal enable as a level
        sig_en = 3'b000; blk_end = 1;
        tick(3'b001, 1'b0, "R4");
        sig_en = 3'b001;
        tick(3'b001, 1'b1, "R4");
        sig_en = 3'b110;
        tick(3'b001, 1'b0, "R4");
        sig_en = 3'b111;
        clear_all();

        // R9: set beats clear; other-bit clear leaves it
        blk_end = 1; clr_we = 1; clr_mask = 3'b001;
        tick(3'b001, 1'b1, "R9");
        clr_we = 1; clr_mask = 3'b110;
        tick(3'b001, 1'b1, "R9");
        clr_we = 1; clr_mask = 3'b001;
        tick(3'b000, 1'b0, "R9");

        // R5: fixed mode uses the flag captured at enable
        per_block = 0; cfg_ioc = 0; chan_en = 1;
        tick(3'b000, 1'b0, "R5");
        cfg_ioc = 1; blk_end = 1;
        tick(3'b000, 1'b0, "R5");
        chan_en = 1;
        tick(3'b000, 1'b0, "R5");
        cfg_ioc = 0; blk_end = 1;
        tick(3'b001, 1'b1, "R5");
        clear_all();
        per_block = 1; cfg_ioc = 1;

        // R7: wait for the flagged write's response, not an earlier one
        np_last_en = 1;
        wr_issue = 1;
        tick(3'b000, 1'b0, "R7");
        wr_issue = 1; wr_issue_last = 1;
        tick(3'b000, 1'b0, "R7");
        blk_end = 1;
        tick(3'b000, 1'b0, "R7");
        b_valid = 1; b_ready = 1;
        tick(3'b000, 1'b0, "R7");
        b_valid = 1; b_ready = 0;
        tick(3'b000, 1'b0, "R7");
        b_valid = 1; b_ready = 1;
        tick(3'b001, 1'b1, "R7");
        clear_all();

        // R7: response arrives before blk_end
        wr_issue = 1; wr_issue_last = 1;
        tick(3'b000, 1'b0, "R7");
        b_valid = 1; b_ready = 1;
        tick(3'b000, 1'b0, "R7");
        blk_end = 1; blk_final = 1;
        tick(3'b011, 1'b1, "R7");
        clear_all();

        // R7: response in the same cycle as blk_end
        wr_issue = 1; wr_issue_last = 1;
        tick(3'b000, 1'b0, "R7");
        blk_end = 1; b_valid = 1; b_ready = 1;
        tick(3'b001, 1'b1, "R7");
        clear_all();

        // R8: erroring final response sets error instead of block done
        wr_issue = 1; wr_issue_last = 1;
        tick(3'b000, 1'b0, "R8");
        blk_end = 1;
        tick(3'b000, 1'b0, "R8");
        b_valid = 1; b_ready = 1; b_err = 1;
        tick(3'b100, 1'b1, "R8");
        clr_we = 1; clr_mask = 3'b100;
        tick(3'b000, 1'b0, "R8");

        repeat (3) @(posedge clk);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule